// File: doc/BRIEF.md
# Per-Channel DAC Output Power Sequencer

This block sits on the host side of a multi-channel DAC and turns per-channel power-on and power-off requests into writes of each channel's DAC control register. For every channel it holds a shadow copy of that control register and one bit of a power-off mask. A request is carried out as a read-modify-write of the shadow, and the updated value goes out as a 24-bit frame to an SPI master. The block waits for the master's done pulse before it moves on.

Powering a channel on takes two frames. The first frame sets the internal enable and the DC-DC enable. A fixed settling time follows, counted in clock cycles from the clock frequency. The second frame then adds the output enable. Powering a channel off takes one frame, which clears all three enables. A request that matches the channel's present mask state is dropped and produces no frame. Requests that arrive during a sequence wait in a per-channel pending slot and are served lowest channel index first. The channel count may be at most 4, because the channel number shares the frame's address field with a fixed base.

Top module: `dac_pwr_seq`

## Requirements
- R1: After reset every bit of `pdn_mask_o` is 1 (all channels off), `busy_o` is 0 and `frame_valid_o` is 0.
- R2: An on-request for a channel whose mask bit is 0, or an off-request for a channel whose mask bit is 1, produces no frame and leaves the mask unchanged.
- R3: The first frame of a power-on carries the shadow with bit 8 (internal enable) and bit 4 (DC-DC enable) set, and all other shadow bits unchanged.
- R4: The second frame of a power-on adds bit 6 (output enable). `frame_valid_o` rises exactly SETTLE_CYC cycles after the clock edge that samples the done pulse of the first frame, where SETTLE_CYC = CLK_HZ/1e6 * SETTLE_US.
- R5: A power-off sends a single frame in which bits 8, 6 and 4 are cleared and all other shadow bits are kept.
- R6: Frame layout: bits 23:21 are 0, bits 20:16 hold 0x1C OR the channel number, bits 15:13 hold the sub-register code 2, and bits 12:0 hold the 13-bit shadow value.
- R7: `frame_valid_o` and `frame_o` stay stable until the cycle in which `frame_done_i` is high. The next frame starts only after that cycle.
- R8: Pending requests are served lowest channel index first. A request that arrives during a sequence is kept and served afterwards.
- R9: `busy_o` is high whenever a request is pending or a sequence is in progress, including the settling wait.
- R10: If an on-request and an off-request reach the same channel in the same cycle, or before that channel is served, the later request is kept, and off wins a tie.
- R11: A channel's mask bit goes to 0 when its first power-on frame is issued, and goes to 1 when its power-off frame is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| up_req_i | input | NCH | Per-channel power-on request, one pulse per request |
| dn_req_i | input | NCH | Per-channel power-off request, one pulse per request |
| frame_done_i | input | 1 | SPI master has finished sending the current frame |
| frame_valid_o | output | 1 | A frame is presented on `frame_o` |
| frame_o | output | 24 | Control-register write frame |
| busy_o | output | 1 | Requests are pending or a sequence is running |
| pdn_mask_o | output | NCH | Per-channel power-off state, 1 = off |

## Verification
The bound checker runs on every cycle. It checks that a frame holds until its done pulse, that every frame has the fixed address and sub-register fields, that the enable bits agree with the mask state of the addressed channel, that busy covers every frame, and that an output-enable frame never comes earlier than the settling window after the previous done. Some behaviour shows only in the directed scenarios, because it depends on the history of requests. These are the exact settling count, the filtering of redundant requests, preservation of the other shadow bits, the order in which queued channels are served, and which request wins when on and off collide.

// File: rtl/dac_pwr_seq_pkg.sv
package dac_pwr_seq_pkg;
  localparam int CTRL_W  = 13;
  localparam int FRAME_W = 24;
  localparam int BIT_INT_EN  = 8;
  localparam int BIT_OUT_EN  = 6;
  localparam int BIT_DCDC_EN = 4;
  localparam logic [4:0] CTRL_ADDR_BASE = 5'h1C;
  localparam logic [2:0] SUB_DAC_CTRL   = 3'd2;

  localparam logic [CTRL_W-1:0] EN_PHASE1 =
    CTRL_W'((1 << BIT_INT_EN) | (1 << BIT_DCDC_EN));
  localparam logic [CTRL_W-1:0] EN_ALL =
    CTRL_W'((1 << BIT_INT_EN) | (1 << BIT_DCDC_EN) | (1 << BIT_OUT_EN));
  localparam logic [CTRL_W-1:0] EN_OUT = CTRL_W'(1 << BIT_OUT_EN);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_SETTLE
  } seq_state_e;
endpackage

// File: rtl/dac_pwr_seq_queue.sv
module dac_pwr_seq_queue #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  up_i,
  input  logic [NCH-1:0]  dn_i,
  input  logic [NCH-1:0]  clr_i,
  output logic [NCH-1:0]  pend_o,
  output logic [NCH-1:0]  dir_dn_o,
  output logic            pick_vld_o,
  output logic [CH_W-1:0] pick_idx_o
);
  logic [NCH-1:0] pend_q, dn_q;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g] <= 1'b0;
        dn_q[g]   <= 1'b0;
      end else begin
        // new request wins over a same-cycle service clear
        if (up_i[g] || dn_i[g]) begin
          pend_q[g] <= 1'b1;
          dn_q[g]   <= dn_i[g];
        end else if (clr_i[g]) begin
          pend_q[g] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    pick_vld_o = 1'b0;
    pick_idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_vld_o = 1'b1;
        pick_idx_o = CH_W'(i);
      end
    end
  end

  assign pend_o   = pend_q;
  assign dir_dn_o = dn_q;
endmodule

// File: rtl/dac_pwr_seq_timer.sv
module dac_pwr_seq_timer #(
  parameter int SETTLE_CYC = 20000,
  parameter int CNT_W      = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= CNT_W'(SETTLE_CYC - 1);
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dac_pwr_seq_frame.sv
module dac_pwr_seq_frame
  import dac_pwr_seq_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic [CH_W-1:0]    ch_i,
  input  logic [CTRL_W-1:0]  val_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [4:0] addr;
  assign addr    = CTRL_ADDR_BASE | 5'(ch_i);
  assign frame_o = {3'b000, addr, SUB_DAC_CTRL, val_i};
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dac_pwr_seq_pkg::*;
#(
  parameter int                NCH       = 4,
  parameter int                CLK_HZ    = 100_000_000,
  parameter int                SETTLE_US = 200,
  parameter logic [CTRL_W-1:0] CTRL_INIT = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NCH-1:0]     up_req_i,
  input  logic [NCH-1:0]     dn_req_i,
  input  logic               frame_done_i,
  output logic               frame_valid_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               busy_o,
  output logic [NCH-1:0]     pdn_mask_o
);
  localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SETTLE_RAW = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int CNT_W      = $clog2(SETTLE_CYC + 1);

  seq_state_e        state_q;
  logic [CH_W-1:0]   cur_ch_q;
  logic              is_up_q, phase2_q;
  logic [NCH-1:0]    mask_q;
  logic [CTRL_W-1:0] shadow_q [NCH];

  logic [NCH-1:0]  pend, dir_dn, clr;
  logic            pick_vld, pick_dn, go_pick, filtered;
  logic [CH_W-1:0] pick_idx;
  logic            tmr_load, tmr_run, tmr_zero;

  dac_pwr_seq_queue #(.NCH(NCH), .CH_W(CH_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_i       (up_req_i),
    .dn_i       (dn_req_i),
    .clr_i      (clr),
    .pend_o     (pend),
    .dir_dn_o   (dir_dn),
    .pick_vld_o (pick_vld),
    .pick_idx_o (pick_idx)
  );

  assign pick_dn  = dir_dn[pick_idx];
  assign go_pick  = (state_q == ST_IDLE) && pick_vld;
  assign filtered = (pick_dn == mask_q[pick_idx]);
  assign clr      = go_pick ? (NCH'(1) << pick_idx) : '0;

  assign tmr_load = (state_q == ST_SEND) && frame_done_i && is_up_q && !phase2_q;
  assign tmr_run  = (state_q == ST_SETTLE);

  dac_pwr_seq_timer #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .run_i  (tmr_run),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cur_ch_q <= '0;
      is_up_q  <= 1'b0;
      phase2_q <= 1'b0;
      mask_q   <= '1;
      for (int i = 0; i < NCH; i++) shadow_q[i] <= CTRL_INIT;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go_pick && !filtered) begin
            cur_ch_q         <= pick_idx;
            is_up_q          <= !pick_dn;
            phase2_q         <= 1'b0;
            mask_q[pick_idx] <= pick_dn;
            if (pick_dn) shadow_q[pick_idx] <= shadow_q[pick_idx] & ~EN_ALL;
            else         shadow_q[pick_idx] <= shadow_q[pick_idx] | EN_PHASE1;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (frame_done_i) state_q <= tmr_load ? ST_SETTLE : ST_IDLE;
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            shadow_q[cur_ch_q] <= shadow_q[cur_ch_q] | EN_OUT;
            phase2_q           <= 1'b1;
            state_q            <= ST_SEND;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  dac_pwr_seq_frame #(.CH_W(CH_W)) u_frame (
    .ch_i    (cur_ch_q),
    .val_i   (shadow_q[cur_ch_q]),
    .frame_o (frame_o)
  );

  assign frame_valid_o = (state_q == ST_SEND);
  assign busy_o        = (state_q != ST_IDLE) || (|pend);
  assign pdn_mask_o    = mask_q;
endmodule

// File: rtl/dac_pwr_seq_chk.sv
module dac_pwr_seq_chk #(
  parameter int NCH        = 4,
  parameter int SETTLE_CYC = 20000
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           frame_done_i,
  input logic           frame_valid_o,
  input logic [23:0]    frame_o,
  input logic           busy_o,
  input logic [NCH-1:0] pdn_mask_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_W-1:0] fch;
  logic [31:0]     gap_q;
  assign fch = frame_o[16 +: CH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  gap_q <= '0;
    else if (frame_valid_o && frame_done_i)       gap_q <= '0;
    else if (!frame_valid_o && gap_q != '1)       gap_q <= gap_q + 1;
  end

  p_frame_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && !frame_done_i |=> frame_valid_o && $stable(frame_o));

  p_frame_fields_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> frame_o[23:21] == 3'b000 && frame_o[20:18] == 3'b111
                      && frame_o[15:13] == 3'd2);

  p_up_enables_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && !pdn_mask_o[fch] |-> frame_o[8] && frame_o[4]);

  p_down_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && pdn_mask_o[fch] |-> !frame_o[8] && !frame_o[6] && !frame_o[4]);

  p_settle_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) && frame_o[6] |-> gap_q >= 32'(SETTLE_CYC));

  p_busy_cover_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> busy_o);
endmodule

bind dac_pwr_seq dac_pwr_seq_chk #(.NCH(NCH), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_done_i  (frame_done_i),
  .frame_valid_o (frame_valid_o),
  .frame_o       (frame_o),
  .busy_o        (busy_o),
  .pdn_mask_o    (pdn_mask_o)
);

// File: tb/tb_dac_pwr_seq.sv
module tb_dac_pwr_seq;
  localparam int NCH = 4;
  localparam int S   = 100;   // 100 MHz, 1 us settle
  localparam logic [12:0] INIT = 13'h0025;
  localparam logic [12:0] V_UP1 = 13'h0135;
  localparam logic [12:0] V_UP2 = 13'h0175;
  localparam logic [12:0] V_DN  = 13'h0025;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] up_req = '0, dn_req = '0;
  logic done = 1'b0;
  logic valid, busy;
  logic [23:0] frame;
  logic [NCH-1:0] mask;
  int n_chk = 0, n_fail = 0;

  always #5ns clk = ~clk;

  dac_pwr_seq #(.NCH(NCH), .CLK_HZ(100_000_000), .SETTLE_US(1), .CTRL_INIT(INIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .up_req_i(up_req), .dn_req_i(dn_req),
    .frame_done_i(done), .frame_valid_o(valid), .frame_o(frame),
    .busy_o(busy), .pdn_mask_o(mask)
  );

  function automatic logic [23:0] exp_frame(input int ch, input logic [12:0] v);
    return {3'b000, 5'h1C | 5'(ch), 3'd2, v};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [NCH-1:0] u, input logic [NCH-1:0] d);
    @(negedge clk); up_req = u; dn_req = d;
    @(negedge clk); up_req = '0; dn_req = '0;
  endtask

  // wait for a frame, compare it, hold it for 'hold' cycles, then ack
  task automatic serve(input logic [23:0] exp, input string tag, input int hold);
    int t = 0;
    while (!valid && t < 2000) begin @(negedge clk); t++; end
    check(valid && frame == exp, tag, frame, exp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(valid && frame == exp, "R7 hold", frame, exp);
    end
    done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (valid) seen = 1; end
    check(!seen, tag, seen, 0);
  endtask

  task automatic t_reset;
    check(mask == 4'hF, "R1 mask", mask, 4'hF);
    check(!busy && !valid, "R1 idle", {busy, valid}, 0);
  endtask

  task automatic t_filter_down;
    pulse('0, 4'b0010);
    quiet(6, "R2 redundant off");
    check(mask == 4'hF && !busy, "R2 mask kept", mask, 4'hF);
  endtask

  task automatic t_power_up;
    int gap = 0;
    pulse(4'b0001, '0);
    check(busy, "R9 busy on request", busy, 1);
    serve(exp_frame(0, V_UP1), "R3 R6 first on frame ch0", 0);
    check(mask == 4'hE, "R11 mask cleared", mask, 4'hE);
    while (!valid && gap < 10000) begin
      check(busy, "R9 busy in settle", busy, 1);
      gap++; @(negedge clk);
    end
    check(gap == S, "R4 settle cycles", gap, S);
    serve(exp_frame(0, V_UP2), "R4 second on frame ch0", 0);
    check(!busy && !valid, "R9 idle after", busy, 0);
  endtask

  task automatic t_filter_up;
    pulse(4'b0001, '0);
    quiet(6, "R2 redundant on");
    check(mask == 4'hE, "R2 mask kept on", mask, 4'hE);
  endtask

  task automatic t_power_down;
    pulse('0, 4'b0001);
    serve(exp_frame(0, V_DN), "R5 off frame ch0", 4);
    check(mask == 4'hF, "R11 mask set", mask, 4'hF);
    quiet(4, "R5 single frame");
  endtask

  task automatic t_queue;
    pulse(4'b0110, '0);
    pulse(4'b1000, '0);
    serve(exp_frame(1, V_UP1), "R8 ch1 first", 0);
    serve(exp_frame(1, V_UP2), "R8 ch1 second", 0);
    serve(exp_frame(2, V_UP1), "R8 ch2 first", 0);
    serve(exp_frame(2, V_UP2), "R8 ch2 second", 0);
    serve(exp_frame(3, V_UP1), "R8 ch3 first", 0);
    serve(exp_frame(3, V_UP2), "R8 ch3 second", 0);
    check(mask == 4'h1, "R11 mask after queue", mask, 4'h1);
  endtask

  task automatic t_collide;
    pulse(4'b1000, 4'b1000);
    serve(exp_frame(3, V_DN), "R10 off wins tie", 0);
    check(mask == 4'h9, "R10 mask", mask, 4'h9);
    // ch2 busy-blocked: off then on queued while ch1 off runs; latest (on) kept -> filtered
    pulse('0, 4'b0010);
    pulse('0, 4'b0100);
    pulse(4'b0100, '0);
    serve(exp_frame(1, V_DN), "R10 ch1 off", 0);
    quiet(6, "R10 later on kept, redundant");
    check(mask == 4'hB, "R10 ch2 still on", mask, 4'hB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_filter_down();
    t_power_up();
    t_filter_up();
    t_power_down();
    t_queue();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule